// File: doc/BRIEF.md
# Program Counter with Program-Memory Steering

This block holds the 16-bit byte address of the next instruction byte and moves it forward one byte per fetch. A jump, call or interrupt sequence replaces it with a new target through a load strobe. For the address it presents, it also tells the bus logic whether the byte must come from the 4 KB on-chip ROM or from external program memory. It then raises a strobe one cycle after each fetch so that the instruction register captures the returned byte.

Memory steering uses two inputs: the current address and the level of an external-access pin. With the pin high, the lowest 4 KB are served on chip and everything above goes out to external memory. With the pin low, every fetch goes external, so a part without usable ROM can run entirely from external memory starting at address 0000h.

Top module: `fetch_addr_unit`

## Requirements
- R1: While reset is asserted, and at the first edge after its release, the fetch address is 0000h and the instruction-register strobe is low.
- R2: A clock edge with the fetch strobe high and the load strobe low advances the fetch address by exactly one.
- R3: A clock edge with the load strobe high sets the fetch address to the target input, whatever the fetch strobe is doing.
- R4: A clock edge with both strobes low leaves the fetch address unchanged.
- R5: A fetch at address FFFFh with no load moves the address to 0000h.
- R6: With the external-access pin low, the select output is 1 (external memory) for every address, 0000h through FFFFh.
- R7: With the pin high and the address in 0000h..0FFFh, the select output is 0 (on-chip ROM).
- R8: For any address of 1000h or above, the select output is 1, whatever the pin level.
- R9: The instruction-register strobe is high in exactly the cycle after a cycle whose fetch strobe was high. This holds even when a load arrived with that fetch. Otherwise the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | One byte is fetched at the current address this cycle |
| load_i | input | 1 | Replace the address with load_addr_i at this edge |
| load_addr_i | input | 16 | Target address for a jump, call or interrupt |
| ext_pin_i | input | 1 | External-access pin level; low forces all fetches external |
| fetch_addr_o | output | 16 | Current program-memory byte address |
| sel_ext_o | output | 1 | 1 = external program memory, 0 = on-chip ROM |
| ir_load_o | output | 1 | Instruction register captures the returned byte |

## Verification
The checker assumes the pin level and the strobes are stable across each sampling edge. It also assumes the steering output is read as a combinational function of the present address and pin, with no notion of a pin change mid-fetch. The bench changes every input only at the falling clock edge. It keeps strobes low during reset, so no property starts from a fetch or load issued before the counter leaves reset. Random loads are biased toward 0FFFh, 1000h and FFFFh, so the ROM boundary and the wrap are crossed many times under both pin levels.

// File: rtl/fau_pkg.sv
package fau_pkg;

  typedef enum logic {
    SRC_ROM = 1'b0,
    SRC_EXT = 1'b1
  } mem_src_t;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2
  } pc_op_t;

  function automatic pc_op_t pick_op(input logic fetch, input logic load);
    if (load)       return PC_JUMP;
    else if (fetch) return PC_STEP;
    else            return PC_HOLD;
  endfunction

endpackage

// File: rtl/fau_pc_reg.sv
module fau_pc_reg
  import fau_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch,
  input  logic          load,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic          step_evt,
  output logic          jump_evt
);

  pc_op_t op;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] cur);
    return cur + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [AW-1:0] next_pc(input pc_op_t o,
                                            input logic [AW-1:0] cur,
                                            input logic [AW-1:0] tgt);
    case (o)
      PC_JUMP: return tgt;
      PC_STEP: return advance(cur);
      default: return cur;
    endcase
  endfunction

  assign op       = pick_op(fetch, load);
  assign step_evt = (op == PC_STEP);
  assign jump_evt = (op == PC_JUMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RST_ADDR;
    else        pc <= next_pc(op, pc, target);
  end

endmodule

// File: rtl/fau_mem_steer.sv
module fau_mem_steer
  import fau_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic [AW-1:0] addr,
  input  logic          ext_pin,
  output mem_src_t      src,
  output logic          in_rom_window
);

  localparam int unsigned ROM_AW  = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;
  localparam bit          ROM_POW2 = ((1 << ROM_AW) == ROM_BYTES);

  generate
    if (ROM_POW2 && (ROM_AW < AW)) begin : g_pow2
      assign in_rom_window = (addr[AW-1:ROM_AW] == '0);
    end else begin : g_cmp
      assign in_rom_window = ({{(32-AW){1'b0}}, addr} < ROM_BYTES);
    end
  endgenerate

  function automatic mem_src_t steer(input logic pin, input logic in_win);
    return (pin && in_win) ? SRC_ROM : SRC_EXT;
  endfunction

  assign src = steer(ext_pin, in_rom_window);

endmodule

// File: rtl/fau_ir_strobe.sv
module fau_ir_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  output logic capture
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capture <= 1'b0;
    else        capture <= fetch;
  end

endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
  import fau_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_i,
  input  logic          load_i,
  input  logic [15:0]   load_addr_i,
  input  logic          ext_pin_i,
  output logic [15:0]   fetch_addr_o,
  output logic          sel_ext_o,
  output logic          ir_load_o
);

  logic [AW-1:0] pc_q;
  logic          step_evt;
  logic          jump_evt;
  logic          in_rom_window;
  mem_src_t      src;

  fau_pc_reg #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch    (fetch_i),
    .load     (load_i),
    .target   (load_addr_i[AW-1:0]),
    .pc       (pc_q),
    .step_evt (step_evt),
    .jump_evt (jump_evt)
  );

  fau_mem_steer #(.AW(AW), .ROM_BYTES(ROM_BYTES)) u_steer (
    .addr          (pc_q),
    .ext_pin       (ext_pin_i),
    .src           (src),
    .in_rom_window (in_rom_window)
  );

  fau_ir_strobe u_ir (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetch   (fetch_i),
    .capture (ir_load_o)
  );

  assign fetch_addr_o = 16'(pc_q);
  assign sel_ext_o    = (src == SRC_EXT);

endmodule

// File: rtl/fau_checker.sv
module fau_checker #(
  parameter int unsigned AW        = 16,
  parameter int unsigned ROM_BYTES = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_i,
  input logic        load_i,
  input logic [15:0] load_addr_i,
  input logic        ext_pin_i,
  input logic [15:0] fetch_addr_o,
  input logic        sel_ext_o,
  input logic        ir_load_o,
  input logic        step_evt,
  input logic        jump_evt,
  input logic        in_rom_window
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_addr_R1: assert (fetch_addr_o == 16'h0000 && !ir_load_o);
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !load_i) |=> fetch_addr_o == 16'($past(fetch_addr_o) + 16'd1));

  assert_step_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> (fetch_i && !load_i));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> fetch_addr_o == $past(load_addr_i));

  assert_jump_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |-> load_i);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_i && !load_i) |=> $stable(fetch_addr_o));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !load_i && fetch_addr_o == 16'hFFFF) |=> fetch_addr_o == 16'h0000);

  assert_pin_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_pin_i |-> sel_ext_o);

  assert_rom_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pin_i && {16'h0, fetch_addr_o} < ROM_BYTES) |-> !sel_ext_o);

  assert_high_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({16'h0, fetch_addr_o} >= ROM_BYTES) |-> (sel_ext_o && !in_rom_window));

  assert_ir_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_i |=> ir_load_o);

  assert_ir_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_i |=> !ir_load_o);

endmodule

bind fetch_addr_unit fau_checker #(.AW(AW), .ROM_BYTES(ROM_BYTES)) u_fau_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_i       (fetch_i),
  .load_i        (load_i),
  .load_addr_i   (load_addr_i),
  .ext_pin_i     (ext_pin_i),
  .fetch_addr_o  (fetch_addr_o),
  .sel_ext_o     (sel_ext_o),
  .ir_load_o     (ir_load_o),
  .step_evt      (step_evt),
  .jump_evt      (jump_evt),
  .in_rom_window (in_rom_window)
);

// File: tb/tb_fetch_addr_unit.sv
module tb_fetch_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_addr_i = 16'h0;
  logic        ext_pin_i = 1'b1;
  logic [15:0] fetch_addr_o;
  logic        sel_ext_o;
  logic        ir_load_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_pc;
  logic        m_ir;

  always #2 clk = ~clk;

  fetch_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .ext_pin_i(ext_pin_i),
    .fetch_addr_o(fetch_addr_o), .sel_ext_o(sel_ext_o), .ir_load_o(ir_load_o)
  );

  function automatic logic [15:0] want_pc(input logic [15:0] pc, input logic f,
                                          input logic l, input logic [15:0] t);
    logic [16:0] wide;
    if (l) return t;
    if (!f) return pc;
    wide = {1'b0, pc} + 17'd1;
    return wide[15:0];
  endfunction

  function automatic logic want_ext(input logic [15:0] pc, input logic pin);
    if (pin == 1'b0) return 1'b1;
    return (pc > 16'h0FFF);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic l, input logic [15:0] t,
                      input logic pin, input string tag);
    @(negedge clk);
    fetch_i = f; load_i = l; load_addr_i = t; ext_pin_i = pin;
    #1;
    if (!pin) check({tag, " R6 select"}, 16'(sel_ext_o), 16'(want_ext(m_pc, pin)));
    else if (m_pc < 16'h1000) check({tag, " R7 select"}, 16'(sel_ext_o), 16'(want_ext(m_pc, pin)));
    else check({tag, " R8 select"}, 16'(sel_ext_o), 16'(want_ext(m_pc, pin)));
    @(posedge clk);
    #1;
    m_pc = want_pc(m_pc, f, l, t);
    m_ir = f;
    check({tag, " R2/R3/R4/R5 addr"}, fetch_addr_o, m_pc);
    check({tag, " R9 ir strobe"}, 16'(ir_load_o), 16'(m_ir));
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] t;
    logic f, l, p;
    int r;
    void'($urandom(32'd7321));
    m_pc = 16'h0; m_ir = 1'b0;
    #11;
    check("R1 reset addr", fetch_addr_o, 16'h0000);
    check("R1 reset ir", 16'(ir_load_o), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", fetch_addr_o, 16'h0000);

    step(1'b1, 1'b0, 16'h0, 1'b1, "R2 first fetch");
    step(1'b0, 1'b0, 16'h0, 1'b1, "R4 idle");
    step(1'b1, 1'b1, 16'h0FFE, 1'b1, "R3 load with fetch");
    step(1'b1, 1'b0, 16'h0, 1'b1, "R7 at 0FFE");
    step(1'b1, 1'b0, 16'h0, 1'b1, "R8 cross to 1000");
    step(1'b0, 1'b0, 16'h0, 1'b0, "R8 pin low high addr");
    step(1'b0, 1'b1, 16'h0000, 1'b0, "R3 load zero");
    step(1'b1, 1'b0, 16'h0, 1'b0, "R6 pin low at 0");
    step(1'b0, 1'b1, 16'hFFFF, 1'b1, "R3 load top");
    step(1'b1, 1'b0, 16'h0, 1'b1, "R5 wrap");
    step(1'b1, 1'b0, 16'h0, 1'b1, "R7 after wrap");
    step(1'b0, 1'b1, 16'hFFFF, 1'b0, "R3 load top pin low");
    step(1'b1, 1'b1, 16'h1234, 1'b0, "R3 load beats fetch at top");

    for (int i = 0; i < 3000; i++) begin
      r = $urandom_range(0, 99);
      f = (r < 70);
      l = ($urandom_range(0, 99) < 12);
      case ($urandom_range(0, 4))
        0: t = 16'h0FFE + 16'($urandom_range(0, 3));
        1: t = 16'hFFFD + 16'($urandom_range(0, 2));
        default: t = 16'($urandom());
      endcase
      p = ($urandom_range(0, 99) < 75);
      step(f, l, t, p, "random");
    end

    step(1'b0, 1'b0, 16'h0, 1'b1, "R9 final idle");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule